// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is the retirement queue of a speculative out-of-order core. When an instruction issues, the block claims the entry at its tail and hands back that entry's index. The index travels with the operands as the destination tag. An instruction may issue only if a reservation station is also free. When a functional unit finishes, it broadcasts its tag and result on the common data bus. The buffer captures that result into the matching live entry. For a branch, the broadcast also carries whether the branch was mispredicted.

Results may arrive in any order. Retirement, however, always follows program order. The oldest entry leaves only once its result is present. A register-writing entry raises a register-file write strobe and a store raises a memory write strobe, each with the destination and value. A correctly predicted branch simply retires. A mispredicted branch at the head retires nothing: in one cycle it empties the whole buffer and pulses a flush output, so every younger speculative instruction is discarded before it can change machine state.

Top module: `rob_inorder`

## Requirements
- R1: After reset the buffer is empty (`rob_empty`=1, `rob_full`=0, `rob_count`=0), `commit_valid` and `flush` are low, and `alloc_tag` is 0.
- R2: `alloc_grant` is high exactly when `alloc_req` and `rs_free` are high, the buffer is not full and no flush is being taken this cycle. `alloc_tag` is the tail index, which advances by one after each grant; a grant raises `rob_count` by one at the clock edge.
- R3: With DEPTH live entries `rob_full` is 1 and further requests are refused, while the count stays at DEPTH.
- R4: A bus write with `cdb_valid`=1 stores `cdb_value` into the live entry named by `cdb_tag`; that value is the one later presented on `commit_value`.
- R5: Only the head entry retires, one per cycle, and only after its result has been captured. Results arriving out of order still retire in allocation order. `commit_valid`, `commit_tag`, `commit_dest` and `commit_value` are registered and appear the cycle after the head became ready.
- R6: The entry kind given at allocation selects the retirement action: kind 0 (register write) sets `commit_reg_we`, kind 1 (store) sets `commit_mem_we`, and kind 2 (branch) retires with both strobes low.
- R7: A kind 2 entry whose result was written with `cdb_mispredict`=1 and that reaches the head causes, at the next edge, `flush`=1 for one cycle, `rob_count`=0, no commit, and the next allocation receives tag 0.
- R8: In the cycle in which that flush is taken, allocation is refused even if requested.
- R9: A bus write naming an entry that is not live is ignored: it neither retires anything nor marks a later allocation of that slot as ready.
- R10: The head and tail indices wrap from DEPTH-1 to 0, and order is preserved across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Issue logic asks for an entry |
| rs_free | input | 1 | A reservation station is available |
| alloc_kind | input | 2 | 0 register write, 1 store, 2 branch |
| alloc_dest | input | DEST_W (5) | Destination register or store tag |
| alloc_grant | output | 1 | Entry granted this cycle |
| alloc_tag | output | TAG_W (4) | Index of the entry a grant claims |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | TAG_W (4) | Entry the result belongs to |
| cdb_value | input | DATA_W (32) | Result value |
| cdb_mispredict | input | 1 | Branch resolved as mispredicted |
| commit_valid | output | 1 | An entry retired |
| commit_reg_we | output | 1 | Retirement writes the register file |
| commit_mem_we | output | 1 | Retirement writes memory |
| commit_tag | output | TAG_W (4) | Index of the retired entry |
| commit_dest | output | DEST_W (5) | Destination of the retired entry |
| commit_value | output | DATA_W (32) | Value of the retired entry |
| flush | output | 1 | Buffer emptied after a mispredict |
| rob_full | output | 1 | All entries live |
| rob_empty | output | 1 | No entry live |
| rob_count | output | CNT_W (5) | Number of live entries |

## Verification
The embedded assertions watch, on every cycle, that the occupancy never exceeds the depth, that no grant is given into a full buffer, that a lone grant grows the count by exactly one, that successive retirements carry consecutive tags, and that a flush always leaves the buffer empty. Only the bench scenarios show that captured values reach the right retirement slot. They also show that kinds map to the right strobes, that results arriving out of order are held back until the head is ready, that a flush discards younger work and restarts tags at zero, and that a stale bus write does not make a later occupant of the same slot look finished.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic             clear,
  output logic [PTR_W-1:0] head,
  output logic [PTR_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
    end else begin
      if (push) tail <= step(tail);
      if (pop)  head <= step(head);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CNT_W'(DEPTH)); // R3
  AST_PUSH_NOT_FULL: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R3
  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst) (push && !pop && !clear) |=> count == $past(count) + CNT_W'(1)); // R2
endmodule

// File: rtl/rob_entry_store.sv
module rob_entry_store import rob_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_en,
  input  logic [PTR_W-1:0]  alloc_idx,
  input  rob_kind_e         alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  input  logic              wr_en,
  input  logic [PTR_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_value,
  input  logic              wr_mp,
  input  logic              clear_all,
  input  logic              retire_en,
  input  logic [PTR_W-1:0]  head_idx,
  output logic              head_valid,
  output logic              head_ready,
  output logic              head_mp,
  output rob_kind_e         head_kind,
  output logic [DEST_W-1:0] head_dest,
  output logic [DATA_W-1:0] head_value
);
  logic [DEPTH-1:0] live_q;
  logic [DEPTH-1:0] done_q;
  logic [DEPTH-1:0] mp_q;

  rob_kind_e         kind_mem  [DEPTH];
  logic [DEST_W-1:0] dest_mem  [DEPTH];
  logic [DATA_W-1:0] value_mem [DEPTH];

  logic wr_hit;
  assign wr_hit = wr_en && live_q[wr_idx];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clear_all) begin
        live_q[i] <= 1'b0;
        done_q[i] <= 1'b0;
        mp_q[i]   <= 1'b0;
      end else if (alloc_en && alloc_idx == PTR_W'(i)) begin
        live_q[i] <= 1'b1;
        done_q[i] <= 1'b0;
        mp_q[i]   <= 1'b0;
      end else begin
        if (retire_en && head_idx == PTR_W'(i)) live_q[i] <= 1'b0;
        if (wr_hit && wr_idx == PTR_W'(i)) begin
          done_q[i] <= 1'b1;
          mp_q[i]   <= wr_mp;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) begin
      kind_mem[alloc_idx] <= alloc_kind;
      dest_mem[alloc_idx] <= alloc_dest;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) value_mem[wr_idx] <= wr_value;
  end

  assign head_valid = live_q[head_idx];
  assign head_ready = done_q[head_idx];
  assign head_mp    = mp_q[head_idx];
  assign head_kind  = kind_mem[head_idx];
  assign head_dest  = dest_mem[head_idx];
  assign head_value = value_mem[head_idx];

  AST_RETIRE_LIVE: assert property (@(posedge clk) disable iff (rst) retire_en |-> (head_valid && head_ready)); // R5
endmodule

// File: rtl/rob_inorder.sv
module rob_inorder import rob_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int DEST_W = 5,
  parameter int DATA_W = 32,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_req,
  input  logic              rs_free,
  input  logic [1:0]        alloc_kind,
  input  logic [DEST_W-1:0] alloc_dest,
  output logic              alloc_grant,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              cdb_mispredict,
  output logic              commit_valid,
  output logic              commit_reg_we,
  output logic              commit_mem_we,
  output logic [TAG_W-1:0]  commit_tag,
  output logic [DEST_W-1:0] commit_dest,
  output logic [DATA_W-1:0] commit_value,
  output logic              flush,
  output logic              rob_full,
  output logic              rob_empty,
  output logic [CNT_W-1:0]  rob_count
);
  logic [TAG_W-1:0]  head;
  logic              head_valid, head_ready, head_mp;
  rob_kind_e         head_kind;
  logic [DEST_W-1:0] head_dest;
  logic [DATA_W-1:0] head_value;
  logic              head_go, flush_now, retire_now;

  assign head_go     = !rob_empty && head_valid && head_ready;
  assign flush_now   = head_go && (head_kind == KIND_BRANCH) && head_mp;
  assign retire_now  = head_go && !flush_now;
  assign alloc_grant = alloc_req && rs_free && !rob_full && !flush_now;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk   (clk),
    .rst   (rst),
    .push  (alloc_grant),
    .pop   (retire_now),
    .clear (flush_now),
    .head  (head),
    .tail  (alloc_tag),
    .count (rob_count),
    .full  (rob_full),
    .empty (rob_empty)
  );

  rob_entry_store #(.DEPTH(DEPTH), .DEST_W(DEST_W), .DATA_W(DATA_W)) u_store (
    .clk        (clk),
    .rst        (rst),
    .alloc_en   (alloc_grant),
    .alloc_idx  (alloc_tag),
    .alloc_kind (rob_kind_e'(alloc_kind)),
    .alloc_dest (alloc_dest),
    .wr_en      (cdb_valid),
    .wr_idx     (cdb_tag),
    .wr_value   (cdb_value),
    .wr_mp      (cdb_mispredict),
    .clear_all  (flush_now),
    .retire_en  (retire_now),
    .head_idx   (head),
    .head_valid (head_valid),
    .head_ready (head_ready),
    .head_mp    (head_mp),
    .head_kind  (head_kind),
    .head_dest  (head_dest),
    .head_value (head_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_valid  <= 1'b0;
      commit_reg_we <= 1'b0;
      commit_mem_we <= 1'b0;
      flush         <= 1'b0;
    end else begin
      commit_valid  <= retire_now;
      commit_reg_we <= retire_now && (head_kind == KIND_REG);
      commit_mem_we <= retire_now && (head_kind == KIND_STORE);
      flush         <= flush_now;
    end
  end

  always_ff @(posedge clk) begin
    if (retire_now) begin
      commit_tag   <= head;
      commit_dest  <= head_dest;
      commit_value <= head_value;
    end
  end

  logic             seen_commit;
  logic [TAG_W-1:0] prev_tag;
  always_ff @(posedge clk) begin
    if (rst || flush) begin
      seen_commit <= 1'b0;
      prev_tag    <= '0;
    end else if (commit_valid) begin
      seen_commit <= 1'b1;
      prev_tag    <= commit_tag;
    end
  end

  AST_COMMIT_ORDER: assert property (@(posedge clk) disable iff (rst) (commit_valid && seen_commit) |-> commit_tag == ((prev_tag == TAG_W'(DEPTH - 1)) ? '0 : prev_tag + 1'b1)); // R5
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush |-> (rob_empty && !commit_valid)); // R7
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) !(commit_reg_we && commit_mem_we)); // R6
endmodule

// File: tb/rob_inorder_tb.sv
`timescale 1ns/1ps
module rob_inorder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        alloc_req, rs_free;
  logic [1:0]  alloc_kind;
  logic [4:0]  alloc_dest;
  logic        alloc_grant;
  logic [3:0]  alloc_tag;
  logic        cdb_valid;
  logic [3:0]  cdb_tag;
  logic [31:0] cdb_value;
  logic        cdb_mispredict;
  logic        commit_valid, commit_reg_we, commit_mem_we;
  logic [3:0]  commit_tag;
  logic [4:0]  commit_dest;
  logic [31:0] commit_value;
  logic        flush, rob_full, rob_empty;
  logic [4:0]  rob_count;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  rob_inorder u_dut (
    .clk(clk), .rst(rst), .alloc_req(alloc_req), .rs_free(rs_free),
    .alloc_kind(alloc_kind), .alloc_dest(alloc_dest), .alloc_grant(alloc_grant),
    .alloc_tag(alloc_tag), .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
    .cdb_value(cdb_value), .cdb_mispredict(cdb_mispredict),
    .commit_valid(commit_valid), .commit_reg_we(commit_reg_we),
    .commit_mem_we(commit_mem_we), .commit_tag(commit_tag),
    .commit_dest(commit_dest), .commit_value(commit_value), .flush(flush),
    .rob_full(rob_full), .rob_empty(rob_empty), .rob_count(rob_count)
  );

  typedef struct packed {
    logic        areq;
    logic        rsf;
    logic [1:0]  kind;
    logic [4:0]  dest;
    logic        cv;
    logic [3:0]  ctag;
    logic [15:0] cval;
    logic        cmp;
    logic        eg;
    logic [3:0]  etag;
    logic        ecv;
    logic [1:0]  ekind;
    logic [3:0]  ectag;
    logic [15:0] ecval;
    logic [4:0]  edest;
    logic [4:0]  ecount;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{1'b1,1'b1,2'd0,5'd3, 1'b0,4'd0,16'h0,1'b0,   1'b1,4'd0, 1'b0,2'd0,4'd0,16'h0,5'd0,  5'd1},
    '{1'b1,1'b1,2'd1,5'd7, 1'b0,4'd0,16'h0,1'b0,   1'b1,4'd1, 1'b0,2'd0,4'd0,16'h0,5'd0,  5'd2},
    '{1'b1,1'b1,2'd2,5'd0, 1'b1,4'd1,16'h22,1'b0,  1'b1,4'd2, 1'b0,2'd0,4'd0,16'h0,5'd0,  5'd3},
    '{1'b1,1'b0,2'd0,5'd9, 1'b1,4'd0,16'h11,1'b0,  1'b0,4'd3, 1'b0,2'd0,4'd0,16'h0,5'd0,  5'd3},
    '{1'b0,1'b0,2'd0,5'd0, 1'b0,4'd0,16'h0,1'b0,   1'b0,4'd3, 1'b1,2'd0,4'd0,16'h11,5'd3, 5'd2},
    '{1'b0,1'b0,2'd0,5'd0, 1'b0,4'd0,16'h0,1'b0,   1'b0,4'd3, 1'b1,2'd1,4'd1,16'h22,5'd7, 5'd1},
    '{1'b0,1'b0,2'd0,5'd0, 1'b0,4'd0,16'h0,1'b0,   1'b0,4'd3, 1'b0,2'd0,4'd0,16'h0,5'd0,  5'd1},
    '{1'b0,1'b0,2'd0,5'd0, 1'b1,4'd2,16'h33,1'b0,  1'b0,4'd3, 1'b0,2'd0,4'd0,16'h0,5'd0,  5'd1},
    '{1'b0,1'b0,2'd0,5'd0, 1'b0,4'd0,16'h0,1'b0,   1'b0,4'd3, 1'b1,2'd2,4'd2,16'h33,5'd0, 5'd0}
  };

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_req = 0; rs_free = 0; alloc_kind = 0; alloc_dest = 0;
    cdb_valid = 0; cdb_tag = 0; cdb_value = 0; cdb_mispredict = 0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin : watchdog
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    idle_inputs();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    // R1 reset state
    check("R1", "empty", rob_empty, 1);
    check("R1", "full", rob_full, 0);
    check("R1", "count", rob_count, 0);
    check("R1", "commit_valid", commit_valid, 0);
    check("R1", "flush", flush, 0);
    check("R1", "alloc_tag", alloc_tag, 0);

    // table walk: R2 R4 R5 R6
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      alloc_req = VECS[i].areq; rs_free = VECS[i].rsf;
      alloc_kind = VECS[i].kind; alloc_dest = VECS[i].dest;
      cdb_valid = VECS[i].cv; cdb_tag = VECS[i].ctag;
      cdb_value = 32'(VECS[i].cval); cdb_mispredict = VECS[i].cmp;
      #1;
      check("R2", "grant", alloc_grant, VECS[i].eg);
      check("R2", "alloc_tag", alloc_tag, VECS[i].etag);
      tick();
      check("R5", "commit_valid", commit_valid, VECS[i].ecv);
      check("R2", "count", rob_count, VECS[i].ecount);
      if (VECS[i].ecv) begin
        check("R5", "commit_tag", commit_tag, VECS[i].ectag);
        check("R4", "commit_value", commit_value, 32'(VECS[i].ecval));
        check("R6", "commit_dest", commit_dest, VECS[i].edest);
        check("R6", "reg_we", commit_reg_we, VECS[i].ekind == 2'd0);
        check("R6", "mem_we", commit_mem_we, VECS[i].ekind == 2'd1);
      end
    end

    // R3 fill to full, R10 wrap (tail starts at 3)
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      idle_inputs();
      alloc_req = 1; rs_free = 1; alloc_kind = 2'd0; alloc_dest = 5'(k);
      #1;
      check("R10", "grant", alloc_grant, 1);
      check("R10", "alloc_tag", alloc_tag, (3 + k) % 16);
      tick();
    end
    check("R3", "full", rob_full, 1);
    check("R3", "count", rob_count, 16);
    @(negedge clk); #1;
    check("R3", "grant when full", alloc_grant, 0);
    tick();
    check("R3", "count held", rob_count, 16);
    for (int k = 15; k >= 0; k--) begin
      @(negedge clk);
      idle_inputs();
      cdb_valid = 1; cdb_tag = 4'((3 + k) % 16); cdb_value = 32'h100 + 32'(k);
      tick();
      check("R5", "held until head ready", commit_valid, 0);
    end
    @(negedge clk); idle_inputs();
    for (int k = 0; k < 16; k++) begin
      tick();
      check("R10", "drain valid", commit_valid, 1);
      check("R10", "drain tag", commit_tag, (3 + k) % 16);
      check("R4", "drain value", commit_value, 32'h100 + 32'(k));
      check("R6", "drain dest", commit_dest, k);
    end
    tick();
    check("R5", "drained", rob_empty, 1);

    // R7 R8 flush on mispredicted branch
    @(negedge clk); alloc_req = 1; rs_free = 1; alloc_kind = 2'd0; alloc_dest = 5'd1; tick();
    @(negedge clk); alloc_kind = 2'd2; alloc_dest = 5'd0; tick();
    @(negedge clk); alloc_kind = 2'd0; alloc_dest = 5'd2; tick();
    check("R7", "count before", rob_count, 3);
    @(negedge clk); idle_inputs(); cdb_valid = 1; cdb_tag = 4'd3; cdb_value = 32'hAA; tick();
    @(negedge clk); cdb_tag = 4'd4; cdb_value = 32'h0; cdb_mispredict = 1; tick();
    check("R7", "older commits", commit_valid, 1);
    check("R7", "older tag", commit_tag, 3);
    @(negedge clk); idle_inputs(); alloc_req = 1; rs_free = 1; #1;
    check("R8", "grant during flush", alloc_grant, 0);
    tick();
    check("R7", "flush", flush, 1);
    check("R7", "count", rob_count, 0);
    check("R7", "no commit", commit_valid, 0);
    @(negedge clk); #1;
    check("R7", "tag restart", alloc_tag, 0);
    check("R7", "grant after", alloc_grant, 1);
    tick();
    check("R7", "flush pulse ends", flush, 0);
    check("R7", "count after", rob_count, 1);

    // R9 stale bus write to a non-live slot
    @(negedge clk); idle_inputs(); cdb_valid = 1; cdb_tag = 4'd1; cdb_value = 32'h99; tick();
    check("R9", "no commit", commit_valid, 0);
    check("R9", "count", rob_count, 1);
    @(negedge clk); idle_inputs(); alloc_req = 1; rs_free = 1; alloc_dest = 5'd4; #1;
    check("R9", "alloc tag", alloc_tag, 1);
    tick();
    @(negedge clk); idle_inputs(); cdb_valid = 1; cdb_tag = 4'd0; cdb_value = 32'h44; tick();
    @(negedge clk); idle_inputs(); tick();
    check("R9", "head commits", commit_valid, 1);
    check("R9", "head value", commit_value, 32'h44);
    tick();
    check("R9", "stale write ignored", commit_valid, 0);
    check("R9", "count", rob_count, 1);
    @(negedge clk); cdb_valid = 1; cdb_tag = 4'd1; cdb_value = 32'h55; tick();
    @(negedge clk); idle_inputs(); tick();
    check("R9", "real write commits", commit_valid, 1);
    check("R9", "real value", commit_value, 32'h55);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule